// File: doc/BRIEF.md
# Weighted Histogram Mapper with Ping-Pong Weight Staging

This block is one mapper worker for a boosting-style ranking trainer. For a single feature it receives 128-bit words, each carrying sixteen packed 8-bit bin codes. Each bin code belongs to one document. The per-document 32-bit weights, which all mappers share, arrive on a separate port four to a beat. For every document the mapper adds that document's weight into the histogram entry its bin code selects. The histogram has 256 entries.

Weights are staged in two register sets of sixteen entries each. One set is refilled while the other is consumed, so the weight transfer overlaps with accumulation. Each bin/weight pair takes a fixed number of cycles, set by a parameter. A bin word is accepted only when a full weight set is waiting for it. When a word flagged as last has been accumulated, the block streams out the 256 entries under valid/ready, each tagged with the feature index. It zeroes each entry as that entry leaves, so the next task starts from an empty histogram.

The controller has three states:
- `ST_WAIT` waits for a bin word.
- `ST_ACCUM` steps through the sixteen pairs.
- `ST_DRAIN` streams the histogram.

Its transitions are:
- `ST_WAIT` goes to `ST_ACCUM` when a bin word is accepted.
- `ST_ACCUM` goes to `ST_WAIT` at the end of a word without the last flag.
- `ST_ACCUM` goes to `ST_DRAIN` at the end of a word with the last flag.
- `ST_DRAIN` goes to `ST_WAIT` when entry 255 is accepted.

Top module: `hist_mapper`

## Requirements
- R1: While reset is asserted and just after it, `out_valid` and `bin_ready` are 0, `wt_ready` is 1, and every histogram entry is zero.
- R2: Weight beat lane k (bits 32k+31 to 32k) is the weight of document 4·b+k within the current set, where b is the beat's position (0 to 3) in that set. Four beats complete one set of sixteen weights.
- R3: `wt_ready` is 1 while at least one of the two weight sets is not full, and 0 when both are full. A set becomes free on the edge that finishes the bin word consuming it. Sets are filled and consumed in alternating order.
- R4: `bin_ready` is 1 only in `ST_WAIT` with a full weight set available. Byte j of a bin word (bits 8j+7 to 8j) is the bin code of document j, paired with weight j of the set, and bytes are consumed from j=0 upward.
- R5: Each pair adds its weight into the entry its bin code selects, as 32-bit unsigned arithmetic with wraparound.
- R6: After a bin word is accepted, `bin_ready` stays 0 for exactly 16·PAIR_CYCLES cycles (208 with the default of 13). It returns to 1 on the next cycle only if the word was not last and a full set is waiting.
- R7: After a word with `bin_last`=1 has been accumulated, the block presents 256 entries with `out_valid`=1, `out_bin` counting 0 to 255. An entry stays unchanged until `out_ready` is 1.
- R8: Every streamed entry carries in `out_feature` the feature index sampled with the most recently accepted bin word.
- R9: Each entry is zeroed when it is accepted on the output, so a following task starts from zero. No bin word is accepted while the histogram is streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bin_valid | input | 1 | Bin word offered |
| bin_ready | output | 1 | Bin word accepted this cycle when valid |
| bin_word | input | WORD_W | Sixteen packed 8-bit bin codes |
| bin_last | input | 1 | Word is the final one of the task |
| bin_feature | input | FEAT_W | Feature index of the task |
| wt_valid | input | 1 | Weight beat offered |
| wt_ready | output | 1 | Weight beat accepted this cycle when valid |
| wt_word | input | WORD_W | Four packed 32-bit weights |
| out_valid | output | 1 | Histogram entry presented |
| out_ready | input | 1 | Consumer takes the entry |
| out_bin | output | 8 | Bin index of the entry |
| out_count | output | WT_W | Accumulated weight of the entry |
| out_feature | output | FEAT_W | Feature index tag |

## Verification
The block is driven with four patterns:
- All sixteen documents in a word share one bin code with distinct weights. This separates a correct sum from a dropped or repeated weight.
- Ascending codes mixed with edge codes 0 and 255. This exposes swapped byte or lane order and any mispairing of bins with weights.
- Maximum weights on one bin. This shows whether the sum wraps at 32 bits.
- Random codes and weights under a stalling output consumer across back-to-back tasks. This checks the ping-pong alternation, output hold behaviour and clearing between tasks.

A bin word offered before any weights, and a third weight set offered while two are full, check the input hold-offs. The gap between accepted bin words measures the per-pair cycle count.

// File: rtl/hmap_pkg.sv
package hmap_pkg;

    localparam int BIN_W    = 8;
    localparam int NUM_BINS = 1 << BIN_W;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_ACCUM,
        ST_DRAIN
    } map_state_t;

endpackage

// File: rtl/hmap_weight_pingpong.sv
// Two register sets of SET_SIZE weights; one is written while the other is read.
module hmap_weight_pingpong #(
    parameter int WORD_W   = 128,
    parameter int WT_W     = 32,
    parameter int SET_SIZE = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [WORD_W-1:0]           in_data,
    output logic                        in_ready,
    input  logic [$clog2(SET_SIZE)-1:0] rd_idx,
    output logic [WT_W-1:0]             rd_weight,
    output logic                        rd_full,
    input  logic                        rd_release
);

    localparam int LANES = WORD_W / WT_W;
    localparam int BEATS = SET_SIZE / LANES;
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [WT_W-1:0] set_q [2][SET_SIZE];
    logic [1:0]      full_q;
    logic            wr_sel_q;
    logic            rd_sel_q;
    logic [BW-1:0]   beat_q;
    logic            accept;
    logic            set_done;

    assign in_ready  = !full_q[wr_sel_q];
    assign accept    = in_valid && in_ready;
    assign set_done  = accept && (beat_q == BW'(BEATS - 1));
    assign rd_full   = full_q[rd_sel_q];
    assign rd_weight = set_q[rd_sel_q][rd_idx];

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int l = 0; l < LANES; l++) begin
                set_q[wr_sel_q][int'(beat_q) * LANES + l] <= in_data[l*WT_W +: WT_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q   <= '0;
            wr_sel_q <= 1'b0;
            rd_sel_q <= 1'b0;
            beat_q   <= '0;
        end else begin
            if (accept) begin
                beat_q <= set_done ? '0 : beat_q + 1'b1;
            end
            if (set_done) begin
                full_q[wr_sel_q] <= 1'b1;
                wr_sel_q         <= !wr_sel_q;
            end
            if (rd_release) begin
                full_q[rd_sel_q] <= 1'b0;
                rd_sel_q         <= !rd_sel_q;
            end
        end
    end

endmodule

// File: rtl/hmap_hist_bank.sv
// Histogram register bank: read-modify-write update port, clear port, read port.
module hmap_hist_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_val,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                mem_q[e] <= '0;
            end
        end else begin
            if (upd_en) begin
                mem_q[upd_addr] <= mem_q[upd_addr] + upd_val;
            end
            if (clr_en) begin
                mem_q[clr_addr] <= '0;
            end
        end
    end

endmodule

// File: rtl/hist_mapper.sv
module hist_mapper
    import hmap_pkg::*;
#(
    parameter int WORD_W      = 128,
    parameter int WT_W        = 32,
    parameter int FEAT_W      = 16,
    parameter int PAIR_CYCLES = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bin_valid,
    output logic              bin_ready,
    input  logic [WORD_W-1:0] bin_word,
    input  logic              bin_last,
    input  logic [FEAT_W-1:0] bin_feature,
    input  logic              wt_valid,
    output logic              wt_ready,
    input  logic [WORD_W-1:0] wt_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BIN_W-1:0]  out_bin,
    output logic [WT_W-1:0]   out_count,
    output logic [FEAT_W-1:0] out_feature
);

    localparam int SET_SIZE = WORD_W / BIN_W;
    localparam int IW       = $clog2(SET_SIZE);
    localparam int CW       = (PAIR_CYCLES > 1) ? $clog2(PAIR_CYCLES) : 1;

    map_state_t        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic              last_q;
    logic [FEAT_W-1:0] feat_q;
    logic [IW-1:0]     pair_q;
    logic [CW-1:0]     cyc_q;
    logic [BIN_W-1:0]  drain_q;

    logic              set_full;
    logic [WT_W-1:0]   cur_weight;
    logic [BIN_W-1:0]  cur_bin;
    logic              bin_take;
    logic              pair_end;
    logic              word_end;
    logic              drain_take;
    logic              upd_en;
    logic              clr_en;
    logic              set_release;

    hmap_weight_pingpong #(
        .WORD_W   (WORD_W),
        .WT_W     (WT_W),
        .SET_SIZE (SET_SIZE)
    ) u_weights (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (wt_valid),
        .in_data    (wt_word),
        .in_ready   (wt_ready),
        .rd_idx     (pair_q),
        .rd_weight  (cur_weight),
        .rd_full    (set_full),
        .rd_release (set_release)
    );

    hmap_hist_bank #(
        .ADDR_W (BIN_W),
        .DATA_W (WT_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .upd_addr (cur_bin),
        .upd_val  (cur_weight),
        .clr_en   (clr_en),
        .clr_addr (drain_q),
        .rd_addr  (drain_q),
        .rd_data  (out_count)
    );

    assign cur_bin    = word_q[int'(pair_q) * BIN_W +: BIN_W];
    assign pair_end   = (state_q == ST_ACCUM) && (cyc_q == CW'(PAIR_CYCLES - 1));
    assign word_end   = pair_end && (pair_q == IW'(SET_SIZE - 1));
    assign bin_take   = bin_valid && bin_ready;
    assign drain_take = out_valid && out_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (bin_valid && set_full) begin
                    state_d = ST_ACCUM;
                end
            end
            ST_ACCUM: begin
                if (word_end) begin
                    state_d = last_q ? ST_DRAIN : ST_WAIT;
                end
            end
            ST_DRAIN: begin
                if (out_ready && (drain_q == BIN_W'(NUM_BINS - 1))) begin
                    state_d = ST_WAIT;
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        bin_ready   = 1'b0;
        out_valid   = 1'b0;
        upd_en      = 1'b0;
        set_release = 1'b0;
        clr_en      = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                bin_ready = set_full;
            end
            ST_ACCUM: begin
                upd_en      = pair_end;
                set_release = word_end;
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                clr_en    = out_ready;
            end
            default: begin
                bin_ready = 1'b0;
            end
        endcase
    end

    assign out_bin     = drain_q;
    assign out_feature = feat_q;

    // Counters and captured word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            last_q  <= 1'b0;
            feat_q  <= '0;
            pair_q  <= '0;
            cyc_q   <= '0;
            drain_q <= '0;
        end else begin
            if (bin_take) begin
                word_q <= bin_word;
                last_q <= bin_last;
                feat_q <= bin_feature;
                pair_q <= '0;
                cyc_q  <= '0;
            end else if (state_q == ST_ACCUM) begin
                if (pair_end) begin
                    cyc_q  <= '0;
                    pair_q <= pair_q + 1'b1;
                end else begin
                    cyc_q  <= cyc_q + 1'b1;
                end
            end
            if (drain_take) begin
                drain_q <= drain_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hist_mapper_checker.sv
module hist_mapper_checker #(
    parameter int WT_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bin_valid,
    input logic            bin_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [7:0]      out_bin,
    input logic [WT_W-1:0] out_count
);

    p_hold_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_bin) && $stable(out_count)));

    p_step_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (out_bin != 8'hFF)) |=> (out_valid && (out_bin == $past(out_bin) + 8'd1)));

    p_start_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_bin == 8'd0));

    p_no_take_in_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !bin_ready);

    p_busy_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_valid && bin_ready) |=> !bin_ready);

endmodule

bind hist_mapper hist_mapper_checker #(.WT_W(WT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bin_valid (bin_valid),
    .bin_ready (bin_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bin   (out_bin),
    .out_count (out_count)
);

// File: tb/hist_mapper_test.sv
`timescale 1ns/1ps
module hist_mapper_test;

    localparam int P = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bin_valid = 1'b0;
    logic         bin_ready;
    logic [127:0] bin_word = '0;
    logic         bin_last = 1'b0;
    logic [15:0]  bin_feature = '0;
    logic         wt_valid = 1'b0;
    logic         wt_ready;
    logic [127:0] wt_word = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [7:0]   out_bin;
    logic [31:0]  out_count;
    logic [15:0]  out_feature;

    int  n_checks = 0;
    int  n_errors = 0;
    int  cycles = 0;
    bit  rnd_ready = 1'b0;
    bit  finished = 1'b0;

    // reference model state
    int          m_phase = 0;
    int          m_full = 0;
    int          m_fill = 0;
    int          m_cnt = 0;
    int          m_idx = 0;
    int          m_done = 0;
    bit          m_last = 1'b0;
    logic [15:0] m_feat = '0;
    logic [31:0] m_hist [256];
    logic [31:0] m_wq [$];

    always #5 clk = !clk;

    hist_mapper #(.PAIR_CYCLES(P)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bin_valid   (bin_valid),
        .bin_ready   (bin_ready),
        .bin_word    (bin_word),
        .bin_last    (bin_last),
        .bin_feature (bin_feature),
        .wt_valid    (wt_valid),
        .wt_ready    (wt_ready),
        .wt_word     (wt_word),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_bin     (out_bin),
        .out_count   (out_count),
        .out_feature (out_feature)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural model, advanced on each rising edge from the bench's own inputs
    always @(posedge clk) begin
        bit b_acc;
        bit w_acc;
        bit o_acc;
        if (!rst_n) begin
            m_phase = 0; m_full = 0; m_fill = 0; m_cnt = 0; m_idx = 0;
            m_wq.delete();
            for (int e = 0; e < 256; e++) m_hist[e] = '0;
        end else begin
            b_acc = bin_valid && (m_phase == 0) && (m_full > 0);
            w_acc = wt_valid && (m_full < 2);
            o_acc = (m_phase == 2) && out_ready;
            if (w_acc) begin
                for (int k = 0; k < 4; k++) m_wq.push_back(wt_word[32*k +: 32]);
                m_fill++;
                if (m_fill == 4) begin m_full++; m_fill = 0; end
            end
            if (m_phase == 0) begin
                if (b_acc) begin
                    m_phase = 1; m_cnt = 16 * P; m_last = bin_last; m_feat = bin_feature;
                    for (int j = 0; j < 16; j++) begin
                        logic [31:0] w;
                        w = m_wq.pop_front();
                        m_hist[bin_word[8*j +: 8]] = m_hist[bin_word[8*j +: 8]] + w;
                    end
                end
            end else if (m_phase == 1) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_full--;
                    m_phase = m_last ? 2 : 0;
                    m_idx = 0;
                end
            end else if (o_acc) begin
                m_hist[m_idx] = '0;
                if (m_idx == 255) begin m_phase = 0; m_done++; end
                else m_idx++;
            end
        end
    end

    // compare on every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R6", "bin_ready", 64'(bin_ready), 64'((m_phase == 0) && (m_full > 0)));
            chk("R3", "wt_ready", 64'(wt_ready), 64'(m_full < 2));
            chk("R7", "out_valid", 64'(out_valid), 64'(m_phase == 2));
            if (m_phase == 2) begin
                chk("R7", "out_bin", 64'(out_bin), 64'(m_idx));
                chk("R2 R5 R9", "out_count", 64'(out_count), 64'(m_hist[m_idx]));
                chk("R8", "out_feature", 64'(out_feature), 64'(m_feat));
            end
        end
    end

    always @(negedge clk) out_ready = rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;

    task automatic report();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            report();
        end
    end

    task automatic send_bin(input logic [127:0] w, input bit last, input logic [15:0] f);
        @(negedge clk);
        bin_valid = 1'b1; bin_word = w; bin_last = last; bin_feature = f;
        while (!bin_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        bin_valid = 1'b0;
    endtask

    task automatic send_wt(input logic [127:0] w);
        @(negedge clk);
        wt_valid = 1'b1; wt_word = w;
        while (!wt_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        wt_valid = 1'b0;
    endtask

    function automatic logic [127:0] wt_beat(input int base, input int mul);
        logic [127:0] r;
        for (int k = 0; k < 4; k++) r[32*k +: 32] = 32'(base + k) * 32'(mul);
        return r;
    endfunction

    task automatic wait_done(input int target);
        while (m_done < target) @(negedge clk);
    endtask

    initial begin
        logic [127:0] word;
        int gap;
        // R1: state during reset
        repeat (3) @(negedge clk);
        chk("R1", "bin_ready in reset", 64'(bin_ready), 64'd0);
        chk("R1", "wt_ready in reset", 64'(wt_ready), 64'd1);
        chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;

        // Task A: two full sets prefetched, all bins equal
        for (int b = 0; b < 8; b++) send_wt(wt_beat(4 * b + 1, 1));
        chk("R3", "wt_ready with both sets full", 64'(wt_ready), 64'd0);
        for (int j = 0; j < 16; j++) word[8*j +: 8] = 8'd17;
        send_bin(word, 1'b0, 16'h0A01);
        gap = 0;
        while (!bin_ready && gap < 10000) begin gap++; @(negedge clk); end
        chk("R6", "cycles between bin words", 64'(gap), 64'(16 * P));
        for (int j = 0; j < 16; j++) word[8*j +: 8] = (j == 0) ? 8'd0 : 8'd255;
        send_bin(word, 1'b1, 16'h0A02);
        wait_done(1);

        // Task B: ascending codes, concurrent weights, stalling consumer
        rnd_ready = 1'b1;
        fork
            for (int b = 0; b < 12; b++) send_wt(wt_beat(100 * b + 3, 7));
            begin
                for (int t = 0; t < 3; t++) begin
                    for (int j = 0; j < 16; j++) word[8*j +: 8] = 8'(j + 16 * t);
                    if (t == 2) word[8*15 +: 8] = 8'd255;
                    send_bin(word, t == 2, 16'h0B00 + 16'(t));
                end
            end
        join
        wait_done(2);

        // Task C: bin word offered before weights, wraparound
        rnd_ready = 1'b0;
        for (int j = 0; j < 16; j++) word[8*j +: 8] = 8'd5;
        fork
            send_bin(word, 1'b1, 16'h0C0C);
            begin
                repeat (6) @(negedge clk);
                chk("R4", "bin_ready without weights", 64'(bin_ready), 64'd0);
                for (int b = 0; b < 4; b++) send_wt({4{32'hFFFF_FFFF}});
            end
        join
        wait_done(3);

        // Task D: random codes and weights, back-to-back
        rnd_ready = 1'b1;
        fork
            for (int b = 0; b < 16; b++)
                send_wt({$urandom(), $urandom(), $urandom(), $urandom()});
            for (int t = 0; t < 4; t++)
                send_bin({$urandom(), $urandom(), $urandom(), $urandom()}, t == 3, 16'h0D00 + 16'(t));
        join
        wait_done(4);
        repeat (3) @(negedge clk);
        chk("R9", "idle after drain", 64'(out_valid), 64'd0);
        report();
    end

endmodule